// File: doc/BRIEF.md
# Serial NAND Status Register Unit

This block keeps the protection, configuration and status registers of a serial NAND memory model. A command front end sends it decoded events: register writes with an address and a data byte, the WriteEnable command and the RESET command. An array controller reports when a program, erase or page-load operation starts and when it finishes, and whether it failed. The read path reports ECC result codes. A separate remapping unit supplies the number of its table entries that are in use.

The unit returns the byte held at any register address. It also drives BUSY and the write-enable latch (WEL) as separate outputs, so the command front end can gate later commands on them. Two configuration bits are one-way locks that only a power-on reset clears. The ECC status field takes account of the read mode. In buffer mode it cannot report "several pages uncorrectable", because that result exists only for continuous reads.

Top module: `nand_status_regs`

## Requirements
- R1: After power-on reset (`rst_n` low), the protection register (address 0) reads 0xF0, with the four protect bits [7:4] set and type [3], write-protect mode [2] and locks [1:0] cleared. The configuration register (address 1) reads 0x10 with `strap_buf` low and 0x18 with it high. The status register (address 2) reads 0x00 while `lut_used` is 0.
- R2: An accepted write to address 0 stores all eight data bits. While the protection-lock bit (configuration bit 6) is 1, a write to address 0 leaves the register unchanged.
- R3: A write to address 1 can only set bit 7 (OTP lock) and bit 6 (protection lock): each becomes its old value OR the data bit. Bits 5 (OTP access), 4 (ECC enable) and 3 (buffer mode, 1 = buffer, 0 = continuous) take the data value. Bits 2:0 always read 0.
- R4: WEL is status bit 1 and the `wel` output. It is set the cycle after `wren_cmd` when the unit is not busy. It is cleared the cycle after any accepted write to address 0 or 1, even one the lock discards, and the cycle after a program or erase operation completes. A page-load completion leaves WEL unchanged. A clear wins over a set in the same cycle.
- R5: BUSY is status bit 0 and the `busy` output. It rises the cycle after a start pulse arrives while the unit is idle, and falls the cycle after `op_done`. Start pulses and `wren_cmd` that arrive while BUSY is high have no effect.
- R6: Program-fail is status bit 3 and erase-fail is status bit 2. Each is cleared when an operation of its own kind starts. At completion it takes the value of `op_fail`, and an operation of the other kind leaves it alone.
- R7: ECC status is status bits 5:4, with 00 clean, 01 corrected, 10 one page uncorrectable and 11 several pages uncorrectable. When ECC is enabled, a valid ECC result loads the code, except that in buffer mode 11 is stored as 10. While ECC is disabled, results are ignored.
- R8: ECC status is cleared only by power-on reset and by `reset_cmd`. If `reset_cmd` and an ECC result arrive in the same cycle, the field becomes 00. Register writes and array operations do not change it.
- R9: The table-full flag (status bit 6) is 1 exactly when `lut_used` is 20 or more.
- R10: Writes that arrive while BUSY is high change nothing. Writes to addresses 2 and 3 change nothing. Address 3 reads 0, and status bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| strap_buf | input | 1 | Variant strap that sets the power-on buffer-mode value |
| reset_cmd | input | 1 | RESET command pulse |
| wr_req | input | 1 | Register write request |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wren_cmd | input | 1 | WriteEnable command pulse |
| prog_start | input | 1 | Program operation started |
| erase_start | input | 1 | Erase operation started |
| load_start | input | 1 | Page-load operation started |
| op_done | input | 1 | Current operation finished |
| op_fail | input | 1 | Failure flag, valid with `op_done` |
| ecc_valid | input | 1 | ECC result valid |
| ecc_code | input | 2 | ECC result code |
| lut_used | input | 5 | Used remapping-table entries |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The writes are tried in several patterns:
- Configuration writes of all ones followed by all zeros. These separate the sticky lock bits from the plain fields.
- Protection writes before and after the lock is set.
- Writes to the status and unused addresses.

ECC codes are sent with ECC enabled and disabled, in both read modes, and together with RESET. This shows whether the 11 code is folded and whether RESET has priority. Operations of each kind are run to completion with and without failure, with WriteEnable and new starts sent in the middle. This separates the program-fail flag from the erase-fail flag, and separates the WEL clear on program or erase completion from its survival across a page load.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    RA_PROT = 2'd0,
    RA_CFG  = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_LOAD  = 2'd3
  } op_kind_e;

  localparam logic [REG_W-1:0] PROT_RST = 8'hF0;

  // Buffer mode cannot report a multi-page failure; fold it to single page.
  function automatic logic [1:0] ecc_fold(input logic [1:0] code, input logic buf_mode);
    ecc_fold = (buf_mode && code == 2'b11) ? 2'b10 : code;
  endfunction

  function automatic logic [REG_W-1:0] cfg_rst_value(input logic strap);
    cfg_rst_value = {3'b000, 1'b1, strap, 3'b000};
  endfunction

  // Lock bits [7:6] are one-way; [5:3] follow data; [2:0] reserved.
  function automatic logic [REG_W-1:0] cfg_merge(input logic [REG_W-1:0] old_q,
                                                 input logic [REG_W-1:0] data);
    cfg_merge = {old_q[7] | data[7], old_q[6] | data[6], data[5:3], 3'b000};
  endfunction
endpackage

// File: rtl/nsr_prot_reg.sv
module nsr_prot_reg
  import nsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             lock,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= PROT_RST;
    else if (we && !lock) q <= wdata;
  end

  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(q));
endmodule

// File: rtl/nsr_cfg_reg.sv
module nsr_cfg_reg
  import nsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= cfg_rst_value(strap);
    else if (we) q <= cfg_merge(q, wdata);
  end

  p_otp_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q[7] |=> q[7]);
  p_prot_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q[6] |=> q[6]);
endmodule

// File: rtl/nsr_stat_reg.sv
module nsr_stat_reg
  import nsr_pkg::*;
#(
  parameter int LUT_DEPTH = 20,
  parameter int LUT_CNT_W = $clog2(LUT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wren_cmd,
  input  logic                 wr_cmd,
  input  logic                 reset_cmd,
  input  logic                 prog_start,
  input  logic                 erase_start,
  input  logic                 load_start,
  input  logic                 op_done,
  input  logic                 op_fail,
  input  logic                 ecc_valid,
  input  logic [1:0]           ecc_code,
  input  logic                 ecc_en,
  input  logic                 buf_mode,
  input  logic [LUT_CNT_W-1:0] lut_used,
  output logic [REG_W-1:0]     q,
  output logic                 busy,
  output logic                 wel
);
  localparam logic [LUT_CNT_W-1:0] LUT_FULL_AT = LUT_CNT_W'(LUT_DEPTH);

  op_kind_e   op_q, start_kind;
  logic       busy_q, wel_q, pfail_q, efail_q;
  logic [1:0] ecc_q;
  logic       start_ok, finish, wel_clr, ecc_load, lut_full;

  assign start_kind = prog_start ? OP_PROG : (erase_start ? OP_ERASE : OP_LOAD);
  assign start_ok   = !busy_q && (prog_start || erase_start || load_start);
  assign finish     = busy_q && op_done;
  assign wel_clr    = wr_cmd || (finish && (op_q == OP_PROG || op_q == OP_ERASE));
  assign ecc_load   = ecc_valid && ecc_en;
  assign lut_full   = lut_used >= LUT_FULL_AT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      busy_q  <= 1'b0;
      pfail_q <= 1'b0;
      efail_q <= 1'b0;
    end else if (start_ok) begin
      op_q   <= start_kind;
      busy_q <= 1'b1;
      if (start_kind == OP_PROG)  pfail_q <= 1'b0;
      if (start_kind == OP_ERASE) efail_q <= 1'b0;
    end else if (finish) begin
      op_q   <= OP_IDLE;
      busy_q <= 1'b0;
      if (op_q == OP_PROG)  pfail_q <= op_fail;
      if (op_q == OP_ERASE) efail_q <= op_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wel_q <= 1'b0;
    else if (wel_clr)              wel_q <= 1'b0;
    else if (wren_cmd && !busy_q)  wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ecc_q <= 2'b00;
    else if (reset_cmd) ecc_q <= 2'b00;
    else if (ecc_load)  ecc_q <= ecc_fold(ecc_code, buf_mode);
  end

  assign q    = {1'b0, lut_full, ecc_q, pfail_q, efail_q, wel_q, busy_q};
  assign busy = busy_q;
  assign wel  = wel_q;

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  p_wel_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> !wel);
  p_pfail_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && prog_start) |=> !q[3]);
  p_ecc_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (q[5:4] == 2'b00));
  p_ecc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_cmd && !ecc_load) |=> $stable(q[5:4]));
endmodule

// File: rtl/nand_status_regs.sv
module nand_status_regs
  import nsr_pkg::*;
#(
  parameter int LUT_DEPTH = 20,
  parameter int LUT_CNT_W = $clog2(LUT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_buf,
  input  logic                 reset_cmd,
  input  logic                 wr_req,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 wren_cmd,
  input  logic                 prog_start,
  input  logic                 erase_start,
  input  logic                 load_start,
  input  logic                 op_done,
  input  logic                 op_fail,
  input  logic                 ecc_valid,
  input  logic [1:0]           ecc_code,
  input  logic [LUT_CNT_W-1:0] lut_used,
  output logic                 busy,
  output logic                 wel
);
  logic [REG_W-1:0] prot_q, cfg_q, stat_q;
  logic             wr_ok, prot_we, cfg_we, reg_wr_cmd;

  assign wr_ok      = wr_req && !busy;
  assign prot_we    = wr_ok && (wr_addr == RA_PROT);
  assign cfg_we     = wr_ok && (wr_addr == RA_CFG);
  assign reg_wr_cmd = prot_we || cfg_we;

  nsr_prot_reg u_prot (
    .clk(clk), .rst_n(rst_n), .we(prot_we), .lock(cfg_q[6]),
    .wdata(wr_data), .q(prot_q)
  );

  nsr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .strap(strap_buf), .we(cfg_we),
    .wdata(wr_data), .q(cfg_q)
  );

  nsr_stat_reg #(.LUT_DEPTH(LUT_DEPTH), .LUT_CNT_W(LUT_CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .wren_cmd(wren_cmd), .wr_cmd(reg_wr_cmd),
    .reset_cmd(reset_cmd), .prog_start(prog_start), .erase_start(erase_start),
    .load_start(load_start), .op_done(op_done), .op_fail(op_fail),
    .ecc_valid(ecc_valid), .ecc_code(ecc_code), .ecc_en(cfg_q[4]),
    .buf_mode(cfg_q[3]), .lut_used(lut_used), .q(stat_q), .busy(busy), .wel(wel)
  );

  always_comb begin
    case (rd_addr)
      RA_PROT: rd_data = prot_q;
      RA_CFG:  rd_data = cfg_q;
      RA_STAT: rd_data = stat_q;
      default: rd_data = '0;
    endcase
  end

  p_busy_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy) |=> ($stable(prot_q) && $stable(cfg_q)));
  p_stat_addr_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr[1]) |=> ($stable(prot_q) && $stable(cfg_q)));
endmodule

// File: tb/sim_nand_status_regs.sv
module sim_nand_status_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, strap_buf = 1'b1, reset_cmd = 1'b0;
  logic       wr_req = 1'b0, wren_cmd = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0, ecc_code = 2'd0;
  logic [7:0] wr_data = 8'd0, rd_data;
  logic       prog_start = 1'b0, erase_start = 1'b0, load_start = 1'b0;
  logic       op_done = 1'b0, op_fail = 1'b0, ecc_valid = 1'b0;
  logic [4:0] lut_used = 5'd0;
  logic       busy, wel;

  int    n_tests = 0, n_fail = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  nand_status_regs u0 (
    .clk(clk), .rst_n(rst_n), .strap_buf(strap_buf), .reset_cmd(reset_cmd),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wren_cmd(wren_cmd), .prog_start(prog_start),
    .erase_start(erase_start), .load_start(load_start), .op_done(op_done),
    .op_fail(op_fail), .ecc_valid(ecc_valid), .ecc_code(ecc_code),
    .lut_used(lut_used), .busy(busy), .wel(wel)
  );

  // Behavioural reference model.
  logic [7:0] m_prot;
  bit m_otpl, m_prl, m_otpe, m_ecce, m_buf, m_busy, m_wel, m_pf, m_ef;
  int m_ecc, m_op;  // op: 0 idle, 1 program, 2 erase, 3 load

  always @(posedge clk or negedge rst_n) begin
    bit acc, fin;
    if (!rst_n) begin
      m_prot = 8'hF0; m_otpl = 0; m_prl = 0; m_otpe = 0; m_ecce = 1;
      m_buf = strap_buf; m_busy = 0; m_wel = 0; m_pf = 0; m_ef = 0;
      m_ecc = 0; m_op = 0;
    end else begin
      acc = wr_req && !m_busy && (wr_addr == 2'd0 || wr_addr == 2'd1);
      fin = m_busy && op_done;
      if (acc || (fin && (m_op == 1 || m_op == 2))) m_wel = 0;
      else if (wren_cmd && !m_busy) m_wel = 1;
      if (reset_cmd) m_ecc = 0;
      else if (ecc_valid && m_ecce) m_ecc = (m_buf && ecc_code == 2'd3) ? 2 : int'(ecc_code);
      if (acc && wr_addr == 2'd0 && !m_prl) m_prot = wr_data;
      if (acc && wr_addr == 2'd1) begin
        m_otpl = m_otpl | wr_data[7]; m_prl = m_prl | wr_data[6];
        m_otpe = wr_data[5]; m_ecce = wr_data[4]; m_buf = wr_data[3];
      end
      if (!m_busy && (prog_start || erase_start || load_start)) begin
        m_busy = 1;
        m_op = prog_start ? 1 : (erase_start ? 2 : 3);
        if (m_op == 1) m_pf = 0;
        if (m_op == 2) m_ef = 0;
      end else if (fin) begin
        if (m_op == 1) m_pf = op_fail;
        if (m_op == 2) m_ef = op_fail;
        m_busy = 0; m_op = 0;
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_prot;
      2'd1: return {m_otpl, m_prl, m_otpe, m_ecce, m_buf, 3'b000};
      2'd2: return {1'b0, (lut_used >= 5'd20), m_ecc[1:0], m_pf, m_ef, m_wel, m_busy};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    chk({cur_tag, " busy"}, {7'd0, busy}, {7'd0, m_busy});
    chk({cur_tag, " wel"}, {7'd0, wel}, {7'd0, m_wel});
    chk({cur_tag, " rd_data"}, rd_data, model_read(rd_addr));
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wr_req = 0; wren_cmd = 0; reset_cmd = 0; prog_start = 0; erase_start = 0;
      load_start = 0; op_done = 0; op_fail = 0; ecc_valid = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_req = 1; wr_addr = a; wr_data = d; cyc();
  endtask

  task automatic ecc_ev(input logic [1:0] c);
    ecc_valid = 1; ecc_code = c; cyc();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cur_tag = "R1";
    cyc(3); rst_n = 1; cyc();
    rd(2'd0, v); chk("R1 prot reset", v, 8'hF0);
    rd(2'd1, v); chk("R1 cfg reset strap1", v, 8'h18);
    rd(2'd2, v); chk("R1 stat reset", v, 8'h00);

    cur_tag = "R2";
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R2 prot write", v, 8'h5A);

    cur_tag = "R3";
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R3 cfg all ones", v, 8'hF8);
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R3 locks sticky", v, 8'hC0);

    cur_tag = "R2";
    wr(2'd0, 8'h33); rd(2'd0, v); chk("R2 locked prot write ignored", v, 8'h5A);

    cur_tag = "R10";
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R10 stat write ignored", v, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R10 addr3 reads 0", v, 8'h00);
    rd(2'd1, v); chk("R10 addr3 write no effect on cfg", v, 8'hC0);

    cur_tag = "R7";
    ecc_ev(2'd1); rd(2'd2, v); chk("R7 ecc ignored when disabled", {6'd0, v[5:4]}, 8'd0);
    wr(2'd1, 8'h10);
    ecc_ev(2'd3); rd(2'd2, v); chk("R7 continuous keeps 11", {6'd0, v[5:4]}, 8'd3);
    wr(2'd1, 8'h18);
    ecc_ev(2'd3); rd(2'd2, v); chk("R7 buffer folds 11 to 10", {6'd0, v[5:4]}, 8'd2);
    ecc_ev(2'd1); rd(2'd2, v); chk("R7 corrected code", {6'd0, v[5:4]}, 8'd1);

    cur_tag = "R8";
    wr(2'd1, 8'h18); rd(2'd2, v); chk("R8 write keeps ecc", {6'd0, v[5:4]}, 8'd1);
    reset_cmd = 1; ecc_valid = 1; ecc_code = 2'd2; cyc();
    rd(2'd2, v); chk("R8 reset beats ecc event", {6'd0, v[5:4]}, 8'd0);
    ecc_ev(2'd2);

    cur_tag = "R4";
    wren_cmd = 1; cyc(); chk("R4 wel set", {7'd0, wel}, 8'd1);
    wr(2'd1, 8'h18); chk("R4 wel cleared by reg write", {7'd0, wel}, 8'd0);
    wren_cmd = 1; wr(2'd0, 8'h00); chk("R4 clear beats set", {7'd0, wel}, 8'd0);
    wren_cmd = 1; cyc();

    cur_tag = "R5";
    prog_start = 1; cyc(); chk("R5 busy rises", {7'd0, busy}, 8'd1);
    chk("R4 wel held while busy", {7'd0, wel}, 8'd1);
    erase_start = 1; cyc();
    cur_tag = "R10";
    wr(2'd1, 8'h00); rd(2'd1, v); chk("R10 write while busy ignored", v, 8'hD8);
    cur_tag = "R6";
    op_done = 1; op_fail = 1; cyc();
    rd(2'd2, v);
    chk("R5 busy falls", {7'd0, v[0]}, 8'd0);
    chk("R4 wel cleared by program done", {7'd0, v[1]}, 8'd0);
    chk("R6 pfail set", {7'd0, v[3]}, 8'd1);
    chk("R6 efail untouched by program", {7'd0, v[2]}, 8'd0);
    chk("R8 ecc survives program", {6'd0, v[5:4]}, 8'd2);
    prog_start = 1; cyc(); rd(2'd2, v); chk("R6 pfail cleared on start", {7'd0, v[3]}, 8'd0);
    cyc(2); op_done = 1; cyc(); rd(2'd2, v); chk("R6 pass keeps pfail 0", {7'd0, v[3]}, 8'd0);
    erase_start = 1; cyc(3); op_done = 1; op_fail = 1; cyc();
    rd(2'd2, v); chk("R6 efail set", {7'd0, v[2]}, 8'd1);
    load_start = 1; cyc(); op_done = 1; op_fail = 1; cyc();
    rd(2'd2, v); chk("R6 load leaves efail", {7'd0, v[2]}, 8'd1);
    erase_start = 1; cyc(); rd(2'd2, v); chk("R6 efail cleared on start", {7'd0, v[2]}, 8'd0);
    op_done = 1; cyc();

    cur_tag = "R5";
    wren_cmd = 1; cyc();
    load_start = 1; cyc();
    prog_start = 1; cyc(); wren_cmd = 1; cyc();
    op_done = 1; cyc();
    rd(2'd2, v);
    chk("R5 ignored start while busy", {7'd0, v[0]}, 8'd0);
    chk("R4 wel kept over page load", {7'd0, v[1]}, 8'd1);
    load_start = 1; cyc(); wr(2'd1, 8'h00); op_done = 1; cyc();
    chk("R4 wel kept, busy write not accepted", {7'd0, wel}, 8'd1);

    cur_tag = "R9";
    lut_used = 5'd19; rd(2'd2, v); chk("R9 not full at 19", {7'd0, v[6]}, 8'd0); cyc();
    lut_used = 5'd20; rd(2'd2, v); chk("R9 full at 20", {7'd0, v[6]}, 8'd1); cyc();
    lut_used = 5'd31; rd(2'd2, v); chk("R9 full above 20", {7'd0, v[6]}, 8'd1);
    chk("R10 bit7 zero", {7'd0, v[7]}, 8'd0); cyc();
    lut_used = 5'd0;

    cur_tag = "R1";
    rst_n = 0; strap_buf = 0; cyc(2);
    rd(2'd1, v); chk("R1 cfg reset strap0", v, 8'h10);
    rd(2'd0, v); chk("R1 prot reset again", v, 8'hF0);
    rd(2'd2, v); chk("R1 stat reset again", v, 8'h00);
    rst_n = 1; cyc(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule